// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of its interrupt request lines gets serviced next. Each source has its own enable bit. One global enable masks every source. Each source also carries a two-bit priority level, built from one bit in a low-priority register and one bit in a high-priority register. Arbitration happens only when the core signals the start of an instruction. The highest pending level wins. A fixed scan order, in which source 0 comes first, settles a tie only among sources of that winning level.

The controller keeps one in-service bit per priority level, so nesting follows strict rules. A request may interrupt a running routine only when its level is strictly above the highest level already in service. The topmost level cannot be interrupted at all.

A granted request is presented as a valid flag plus a source index, and both are held until the core acknowledges them. The acknowledge marks the level in service. A return strobe from the core retires the highest in-service level. Software programs the enables and priorities through a plain write/read register port.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, the enable, global-enable, low-priority and high-priority registers read 0, all in-service bits read 0, and vec_req is 0.
- R2: The register port decodes as follows: address 0 holds the source enables (bit i is source i). Address 1 bit 0 is the global enable. Address 2 holds the low priority bits and address 3 the high priority bits, with bit i belonging to source i. Address 4 is read-only and holds the in-service bits in bits 3:0, where bit l is level l. A write takes effect at the clock edge where wr_en is high, and rdata shows the register at addr in the same cycle.
- R3: A source whose enable bit is 0 is never granted, even when it is pending at a higher level than the others.
- R4: While the global enable is 0, no request is granted, whatever the per-source enables hold.
- R5: The level of source i is {high bit i, low bit i}, with 3 the highest. Among eligible pending sources, one at the highest level is granted.
- R6: When several eligible sources share the winning level, the lowest index is granted. A lower index at a lower level never wins over a higher level.
- R7: Arbitration happens only in a cycle where insn_start is 1 and no request is outstanding. The grant shows on vec_req and vec_idx after that clock edge. Without insn_start, no grant appears.
- R8: Once vec_req is 1, vec_req and vec_idx hold until vec_ack is 1, even if new requests or instruction starts arrive. The acknowledge clears vec_req and sets the in-service bit of the granted level.
- R9: A source is granted only if its level is strictly above the highest level in service. An equal or lower level waits, and while level 3 is in service nothing is granted.
- R10: A reti pulse clears the highest set in-service bit and has no effect when none is set. When vec_ack and reti fall in the same cycle, the highest previously set bit is cleared and the granted level's bit is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr |
| irq_src | input | 8 | Pending request flags, bit i is source i |
| insn_start | input | 1 | Instruction boundary strobe from the core |
| vec_ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_req | output | 1 | A granted vector is waiting |
| vec_idx | output | 3 | Index of the granted source |

## Verification
An acknowledge and a return strobe can land in the same cycle. In that case the in-service stack must both retire its old top level and push the newly granted level. To provoke this, two levels are placed in service, a higher-level request is granted, and vec_ack and reti are pulsed together. The result is judged on the in-service readback, which must show the old top bit cleared and the new level's bit set. A second overlap is a new instruction start while a grant is still waiting. The bench checks this by confirming that vec_idx does not move toward a newly raised higher source.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_N = 4;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam logic [2:0] A_ENABLE = 3'd0;
  localparam logic [2:0] A_GLOBAL = 3'd1;
  localparam logic [2:0] A_PRIO_L = 3'd2;
  localparam logic [2:0] A_PRIO_H = 3'd3;
  localparam logic [2:0] A_INSERV = 3'd4;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LVL_N-1:0]  isr,
  output logic [DATA_W-1:0] rdata,
  output logic [NSRC-1:0]   en_q,
  output logic              gie_q,
  output logic [NSRC-1:0]   plo_q,
  output logic [NSRC-1:0]   phi_q
);
  logic [NSRC-1:0] en_d, plo_d, phi_d;
  logic            gie_d;

  always_comb begin
    en_d  = en_q;
    gie_d = gie_q;
    plo_d = plo_q;
    phi_d = phi_q;
    if (wr_en) begin
      case (addr)
        ADDR_W'(A_ENABLE): en_d  = wdata[NSRC-1:0];
        ADDR_W'(A_GLOBAL): gie_d = wdata[0];
        ADDR_W'(A_PRIO_L): plo_d = wdata[NSRC-1:0];
        ADDR_W'(A_PRIO_H): phi_d = wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
      plo_q <= '0;
      phi_q <= '0;
    end else if (wr_en) begin
      en_q  <= en_d;
      gie_q <= gie_d;
      plo_q <= plo_d;
      phi_q <= phi_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_ENABLE): rdata[NSRC-1:0]  = en_q;
      ADDR_W'(A_GLOBAL): rdata[0]         = gie_q;
      ADDR_W'(A_PRIO_L): rdata[NSRC-1:0]  = plo_q;
      ADDR_W'(A_PRIO_H): rdata[NSRC-1:0]  = phi_q;
      ADDR_W'(A_INSERV): rdata[LVL_N-1:0] = isr;
      default: ;
    endcase
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  elig,
  input  logic [NSRC-1:0]  plo,
  input  logic [NSRC-1:0]  phi,
  input  logic             isr_any,
  input  lvl_t             top_lvl,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output lvl_t             win_lvl
);
  logic [NSRC-1:0] cand [LVL_N];
  logic [LVL_N-1:0] lvl_hit;

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    logic allowed;
    assign allowed = !isr_any || (lvl_t'(l) > top_lvl);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign cand[l][i] = allowed && elig[i] && ({phi[i], plo[i]} == lvl_t'(l));
    end
    assign lvl_hit[l] = |cand[l];
  end

  always_comb begin
    win_lvl = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (lvl_hit[l]) win_lvl = lvl_t'(l);
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[win_lvl][i]) win_idx = IDX_W'(i);
    end
  end

  assign win_valid = |lvl_hit;

  // R3
  win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_idx]);

  // R9
  win_above_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && isr_any) |-> (win_lvl > top_lvl));
endmodule

// File: rtl/nic_isr_stack.sv
module nic_isr_stack
  import nic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  lvl_t             push_lvl,
  input  logic             pop,
  output logic [LVL_N-1:0] isr_q,
  output logic             isr_any,
  output lvl_t             top_lvl
);
  logic [LVL_N-1:0] isr_d, top_oh, push_oh;

  always_comb begin
    top_lvl = '0;
    top_oh  = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (isr_q[l]) begin
        top_lvl = lvl_t'(l);
        top_oh  = LVL_N'(1) << l;
      end
    end
  end

  assign isr_any = |isr_q;
  assign push_oh = push ? (LVL_N'(1) << push_lvl) : '0;

  always_comb begin
    isr_d = isr_q;
    if (pop) isr_d = isr_d & ~top_oh;
    isr_d = isr_d | push_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr_q <= '0;
    else if (push || pop) isr_q <= isr_d;
  end

  // R10
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && isr_any) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !isr_any) |=> (isr_q == '0));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              insn_start,
  input  logic              vec_ack,
  input  logic              reti,
  output logic              vec_req,
  output logic [IDX_W-1:0]  vec_idx
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [NSRC-1:0]  en_q, plo_q, phi_q, elig;
  logic             gie_q;
  logic [LVL_N-1:0] isr_q;
  logic             isr_any, win_valid;
  lvl_t             top_lvl, win_lvl;
  logic [IDX_W-1:0] win_idx;

  nic_regs #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .isr(isr_q), .rdata(rdata), .en_q(en_q), .gie_q(gie_q),
    .plo_q(plo_q), .phi_q(phi_q));

  assign elig = irq_src & en_q & {NSRC{gie_q}};

  nic_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n_s), .elig(elig), .plo(plo_q), .phi(phi_q),
    .isr_any(isr_any), .top_lvl(top_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl));

  logic             req_q, req_d, vec_ld, vec_clr;
  logic [IDX_W-1:0] idx_q, idx_d;
  lvl_t             lvl_q, lvl_d;

  assign vec_clr = req_q && vec_ack;
  assign vec_ld  = !req_q && insn_start && win_valid;

  always_comb begin
    req_d = req_q;
    idx_d = idx_q;
    lvl_d = lvl_q;
    if (vec_clr) begin
      req_d = 1'b0;
    end else if (vec_ld) begin
      req_d = 1'b1;
      idx_d = win_idx;
      lvl_d = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (vec_clr || vec_ld) begin
      req_q <= req_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
    end
  end

  nic_isr_stack u_isr (
    .clk(clk), .rst_n(rst_n_s), .push(vec_clr), .push_lvl(lvl_q), .pop(reti),
    .isr_q(isr_q), .isr_any(isr_any), .top_lvl(top_lvl));

  assign vec_req = req_q;
  assign vec_idx = idx_q;

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vec_req && !vec_ack) |=> (vec_req && $stable(vec_idx)));

  // R4
  grant_gie_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(vec_req) |-> $past(gie_q));

  // R7
  grant_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(vec_req) |-> $past(insn_start));

  // R9
  grant_nest_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(vec_req) |-> (!$past(isr_any) || (lvl_q > $past(top_lvl))));
endmodule

// File: tb/sim_nested_irq_ctrl.sv
module sim_nested_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_src = '0;
  logic       insn_start = 1'b0;
  logic       vec_ack = 1'b0;
  logic       reti = 1'b0;
  logic       vec_req;
  logic [2:0] vec_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nested_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_src(irq_src), .insn_start(insn_start),
    .vec_ack(vec_ack), .reti(reti), .vec_req(vec_req), .vec_idx(vec_idx));

  // {enable, prio_low, prio_high, sources, expected req, expected idx}
  localparam logic [47:0] VEC [8] = '{
    {8'hFF, 8'h00, 8'h00, 8'h0C, 8'h01, 8'h02},  // R6 tie at level 0
    {8'hFF, 8'h08, 8'h00, 8'h0C, 8'h01, 8'h03},  // R5 level 1 beats level 0
    {8'hFF, 8'h00, 8'h80, 8'h81, 8'h01, 8'h07},  // R6 higher level beats low index
    {8'h7F, 8'h00, 8'h80, 8'h81, 8'h01, 8'h00},  // R3 disabled high source skipped
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00},  // R3 nothing enabled
    {8'hFF, 8'h50, 8'h50, 8'h50, 8'h01, 8'h04},  // R6 tie at level 3
    {8'hFF, 8'h20, 8'h40, 8'h61, 8'h01, 8'h06},  // R5 three levels
    {8'hFF, 8'h01, 8'h02, 8'h03, 8'h01, 8'h01}   // R5 level 2 over level 1
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_insn();
    @(negedge clk); insn_start = 1'b1;
    @(negedge clk); insn_start = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit r);
    @(negedge clk); vec_ack = a; reti = r;
    @(negedge clk); vec_ack = 1'b0; reti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 vec_req", vec_req, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R1 reg", d, 0);
    end

    // R2 readback
    wr(3'd0, 8'hA5); rd(3'd0, d); chk("R2 enable", d, 8'hA5);
    wr(3'd2, 8'h3C); rd(3'd2, d); chk("R2 prio_low", d, 8'h3C);
    wr(3'd3, 8'hC3); rd(3'd3, d); chk("R2 prio_high", d, 8'hC3);

    // R4 global enable clear
    wr(3'd0, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    irq_src = 8'hFF;
    pulse_insn();
    chk("R4 gie off", vec_req, 0);

    // R7 no grant without insn_start
    wr(3'd1, 8'h01); rd(3'd1, d); chk("R2 global", d, 8'h01);
    repeat (3) @(negedge clk);
    chk("R7 no boundary", vec_req, 0);
    irq_src = 8'h00;

    // Table walk: R3 R5 R6
    for (int k = 0; k < 8; k++) begin
      wr(3'd0, VEC[k][47:40]);
      wr(3'd2, VEC[k][39:32]);
      wr(3'd3, VEC[k][31:24]);
      irq_src = VEC[k][23:16];
      pulse_insn();
      chk("R5 table req", vec_req, int'(VEC[k][15:8]));
      if (VEC[k][8]) begin
        chk("R6 table idx", vec_idx, int'(VEC[k][7:0]));
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
      end
      irq_src = 8'h00;
    end
    rd(3'd4, d); chk("R10 stack empty after table", d, 0);

    // Nesting: src0 lvl1, src1 lvl2, src2 lvl1, src3 lvl3
    wr(3'd0, 8'hFF); wr(3'd2, 8'h0D); wr(3'd3, 8'h0A);
    irq_src = 8'h01; pulse_insn();
    chk("R7 grant src0", vec_req, 1);
    chk("R5 idx src0", vec_idx, 0);
    pulse(1'b1, 1'b0);
    chk("R8 ack clears req", vec_req, 0);
    rd(3'd4, d); chk("R8 isr level1", d, 8'h02);

    irq_src = 8'h04; pulse_insn();
    chk("R9 equal level waits", vec_req, 0);

    irq_src = 8'h02; pulse_insn();
    chk("R9 higher preempts", vec_req, 1);
    chk("R9 idx src1", vec_idx, 1);
    irq_src = 8'h08; pulse_insn();
    chk("R8 req held", vec_req, 1);
    chk("R8 idx held", vec_idx, 1);
    pulse(1'b1, 1'b0);
    rd(3'd4, d); chk("R8 isr levels 1,2", d, 8'h06);

    pulse_insn();
    chk("R9 level3 grant", vec_idx, 3);
    pulse(1'b1, 1'b0);
    rd(3'd4, d); chk("R8 isr levels 1,2,3", d, 8'h0E);

    irq_src = 8'h0F; pulse_insn();
    chk("R9 top level blocks", vec_req, 0);

    pulse(1'b0, 1'b1);
    rd(3'd4, d); chk("R10 reti clears top", d, 8'h06);

    // R10 ack and reti together
    irq_src = 8'h08; pulse_insn();
    chk("R10 setup grant", vec_idx, 3);
    pulse(1'b1, 1'b1);
    rd(3'd4, d); chk("R10 ack+reti", d, 8'h0A);
    chk("R10 req cleared", vec_req, 0);
    irq_src = 8'h00;
    pulse(1'b0, 1'b1);
    rd(3'd4, d); chk("R10 reti to level1", d, 8'h02);
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    rd(3'd4, d); chk("R10 reti on empty", d, 8'h00);

    // R1 reset mid-run
    irq_src = 8'h01; pulse_insn();
    pulse(1'b1, 1'b0);
    irq_src = 8'h02; pulse_insn();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 req after reset", vec_req, 0);
    rd(3'd4, d); chk("R1 isr after reset", d, 0);
    rd(3'd0, d); chk("R1 enable after reset", d, 0);
    rd(3'd3, d); chk("R1 prio_high after reset", d, 0);
    irq_src = 8'h00;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule